// File: doc/BRIEF.md
# Dual-Lane Packed FIR Accumulation Engine

This block computes one output of a finite impulse response filter. Each clock it fetches one 32-bit coefficient word and one 32-bit sample word. Both words carry two signed 16-bit values. Two multipliers run side by side, one on the upper halves and one on the lower halves. Both products are added into a 40-bit accumulator in a single step, so each word pair retires two filter taps per clock.

The engine is started with a word-pair count, a circular coefficient buffer and a linear sample region. The coefficient buffer is given as a base address, a length in words and a starting offset. The sample region is given as a base address. At start the engine also takes the index of one of eight accumulator entries, an optional one-bit left shift applied to each product with signed saturation, and an optional saturation of the 40-bit total to a 32-bit output.

The engine drives two synchronous memory read ports. Read data is expected on the clock after the address. The work runs in three steps: the operands are registered, the products are registered, and then the accumulation happens. The engine raises a one-cycle done pulse once the last products have been added.

Top module: `dual_mac_fir`

## Requirements
- R1: After reset the engine is idle: busy, done, coefRdEn and sampRdEn are 0, and result is 0.
- R2: A start accepted while idle clears the accumulator entry chosen by accSel. It then raises both read enables for exactly pairCount consecutive cycles, beginning in the cycle after the start edge. A rerun of the same job gives the same result and does not add to the previous total.
- R3: In the k-th read cycle, coefAddr equals coefBase + idx (mod 256). idx starts at coefOfs and increments by one, returning to 0 after coefMod-1. The configuration must satisfy coefOfs < coefMod.
- R4: In the k-th read cycle (k from 0), sampAddr equals sampBase + k (mod 256).
- R5: For each word pair, the entry grows by C[31:16]*S[31:16] + C[15:0]*S[15:0]. All values are signed 16-bit. The sum wraps as 40-bit two's complement.
- R6: With shiftEn=1, each 32-bit product is doubled before it is added. A doubled product outside the signed 32-bit range is clamped to 0x7FFFFFFF or 0x80000000.
- R7: With satEn=1, result is the entry clamped to the signed 32-bit range (0x7FFFFFFF or 0x80000000). With satEn=0, result is the entry's low 32 bits.
- R8: For pairCount N>0, done is high for exactly one cycle, which is cycle N+4 after the start edge. result holds the final value from then until the next start.
- R9: With pairCount=0, no reads occur and done pulses in the cycle after the start edge with result 0.
- R10: A start asserted while busy is ignored: the running job's reads, timing and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job (taken only when idle) |
| pairCount | input | 8 | Number of word pairs (two taps each) |
| coefBase | input | 8 | Coefficient buffer base address |
| coefMod | input | 8 | Coefficient buffer length in words |
| coefOfs | input | 8 | First coefficient offset inside the buffer |
| sampBase | input | 8 | First sample word address |
| accSel | input | 3 | Accumulator entry for this job |
| shiftEn | input | 1 | Double each product with saturation |
| satEn | input | 1 | Clamp result to signed 32 bits |
| coefRdEn | output | 1 | Coefficient memory read strobe |
| coefAddr | output | 8 | Coefficient memory address |
| coefData | input | 32 | Coefficient word, valid the cycle after the read |
| sampRdEn | output | 1 | Sample memory read strobe |
| sampAddr | output | 8 | Sample memory address |
| sampData | input | 32 | Sample word, valid the cycle after the read |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | Selected accumulator, saturated or truncated |

## Verification
The bench places the coefficient window where the circular index wraps before the end of the job, and places the sample run across the top of the address space. An engine that wraps late, or carries the base into the wrap, would read the wrong words and compute a different total. Operands of -32768 on both sides make the doubled product overflow. A design without clamping there, or one that clamps only the final total, gives a different low word. Large positive and negative totals exercise the output clamp. A zero-length job checks that no read is issued and the pulse still comes. A second start pulse in the middle of a job checks that a design which restarts or takes the new settings is caught through a changed total or a changed done cycle.

// File: rtl/fir_pkg.sv
package fir_pkg;
  // Per-cycle controls handed from the sequencer to the datapath.
  typedef struct packed {
    logic clr;     // job accepted: clear chosen entry, latch options
    logic ldOp;    // memory words are valid: capture operands
    logic ldProd;  // operands valid: capture scaled products
    logic accEn;   // products valid: add into the entry
  } firStrobes_t;
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  pairCount,
  input  logic [ADDR_W-1:0] coefBase,
  input  logic [ADDR_W-1:0] coefMod,
  input  logic [ADDR_W-1:0] coefOfs,
  input  logic [ADDR_W-1:0] sampBase,
  output logic              coefRdEn,
  output logic [ADDR_W-1:0] coefAddr,
  output logic              sampRdEn,
  output logic [ADDR_W-1:0] sampAddr,
  output logic              busy,
  output logic              done,
  output firStrobes_t       strobes
);
  logic [CNT_W-1:0]  remain;
  logic [ADDR_W-1:0] coefIdx, sampIdx, baseC, baseS, modLat;
  logic              v1, v2, v3;
  logic              startOk, rdEn, lastAcc;

  assign startOk = start && !busy;
  assign rdEn    = busy && (remain != '0);
  assign lastAcc = v3 && !v2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      remain  <= '0;
      coefIdx <= '0;
      sampIdx <= '0;
      baseC   <= '0;
      baseS   <= '0;
      modLat  <= '0;
      v1      <= 1'b0;
      v2      <= 1'b0;
      v3      <= 1'b0;
    end else begin
      if (startOk) begin
        baseC   <= coefBase;
        baseS   <= sampBase;
        modLat  <= coefMod;
        coefIdx <= coefOfs;
        sampIdx <= '0;
        remain  <= pairCount;
        busy    <= (pairCount != '0);
      end else if (rdEn) begin
        remain  <= remain - 1'b1;
        coefIdx <= (coefIdx + 1'b1 == modLat) ? '0 : coefIdx + 1'b1;
        sampIdx <= sampIdx + 1'b1;
      end
      if (lastAcc) busy <= 1'b0;
      v1   <= rdEn;
      v2   <= v1;
      v3   <= v2;
      done <= lastAcc || (startOk && pairCount == '0);
    end
  end

  assign coefRdEn = rdEn;
  assign sampRdEn = rdEn;
  assign coefAddr = baseC + coefIdx;
  assign sampAddr = baseS + sampIdx;

  assign strobes.clr    = startOk;
  assign strobes.ldOp   = v1;
  assign strobes.ldProd = v2;
  assign strobes.accEn  = v3;

  // R3: circular index never leaves the buffer
  a_r3_idx_in_buffer: assert property (@(posedge clk) disable iff (!rstN)
    coefRdEn |-> coefIdx < modLat);
  // R4: consecutive sample reads step by exactly one word
  a_r4_samp_step: assert property (@(posedge clk) disable iff (!rstN)
    (sampRdEn && $past(sampRdEn)) |-> sampAddr == $past(sampAddr) + 1'b1);
  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: no memory traffic while idle
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !coefRdEn && !sampRdEn);
  // R10: a start during a job leaves the remaining count counting down
  a_r10_busy_start: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && remain != '0) |=> remain == $past(remain) - 1'b1);
endmodule

// File: rtl/fir_dp.sv
module fir_dp
  import fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int OUT_W  = 32,
  parameter int NACC   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  firStrobes_t             strobes,
  input  logic [$clog2(NACC)-1:0] accSel,
  input  logic                    shiftEn,
  input  logic                    satEn,
  input  logic [2*DATA_W-1:0]     coefData,
  input  logic [2*DATA_W-1:0]     sampData,
  output logic [OUT_W-1:0]        result
);
  localparam int WORD_W = 2 * DATA_W;
  localparam int PROD_W = 2 * DATA_W;
  localparam int IDX_W  = $clog2(NACC);
  localparam int LANES  = 2;
  localparam logic signed [PROD_W-1:0] P_MAX = {1'b0, {(PROD_W-1){1'b1}}};
  localparam logic signed [PROD_W-1:0] P_MIN = {1'b1, {(PROD_W-1){1'b0}}};
  localparam logic signed [ACC_W-1:0] O_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] O_MIN =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic [WORD_W-1:0]        opC, opS;
  logic [IDX_W-1:0]         selLat;
  logic                     shLat, satLat;
  logic signed [PROD_W-1:0] scaled [LANES];
  logic signed [PROD_W-1:0] prodR  [LANES];
  logic signed [ACC_W-1:0]  accFile [NACC];
  logic signed [ACC_W-1:0]  accCur, accNext;

  // lane 0 multiplies the low halves, lane 1 the high halves
  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic signed [DATA_W-1:0] a, b;
    logic signed [PROD_W-1:0] raw;
    logic                     ovf;
    assign a   = opC[g*DATA_W +: DATA_W];
    assign b   = opS[g*DATA_W +: DATA_W];
    assign raw = a * b;
    assign ovf = raw[PROD_W-1] ^ raw[PROD_W-2];
    assign scaled[g] = !shLat ? raw :
                       ovf ? (raw[PROD_W-1] ? P_MIN : P_MAX) : (raw <<< 1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opC    <= '0;
      opS    <= '0;
      selLat <= '0;
      shLat  <= 1'b0;
      satLat <= 1'b0;
      for (int i = 0; i < LANES; i++) prodR[i] <= '0;
    end else begin
      if (strobes.clr) begin
        selLat <= accSel;
        shLat  <= shiftEn;
        satLat <= satEn;
      end
      if (strobes.ldOp) begin
        opC <= coefData;
        opS <= sampData;
      end
      if (strobes.ldProd)
        for (int i = 0; i < LANES; i++) prodR[i] <= scaled[i];
    end
  end

  assign accCur  = accFile[selLat];
  assign accNext = accCur + ACC_W'(prodR[0]) + ACC_W'(prodR[1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NACC; i++) accFile[i] <= '0;
    end else if (strobes.clr) begin
      accFile[accSel] <= '0;
    end else if (strobes.accEn) begin
      accFile[selLat] <= accNext;
    end
  end

  always_comb begin
    result = accCur[OUT_W-1:0];
    if (satLat) begin
      if (accCur > O_MAX)      result = O_MAX[OUT_W-1:0];
      else if (accCur < O_MIN) result = O_MIN[OUT_W-1:0];
    end
  end

  // R2: the chosen entry reads zero right after a job is accepted
  a_r2_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clr |=> accFile[selLat] == '0);
  // R5: the entry only moves when products are being added
  a_r5_acc_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.accEn && !strobes.clr) |=> accFile[selLat] == $past(accFile[selLat]));
endmodule

// File: rtl/dual_mac_fir.sv
module dual_mac_fir
  import fir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int OUT_W  = 32,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 8,
  parameter int NACC   = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [CNT_W-1:0]        pairCount,
  input  logic [ADDR_W-1:0]       coefBase,
  input  logic [ADDR_W-1:0]       coefMod,
  input  logic [ADDR_W-1:0]       coefOfs,
  input  logic [ADDR_W-1:0]       sampBase,
  input  logic [$clog2(NACC)-1:0] accSel,
  input  logic                    shiftEn,
  input  logic                    satEn,
  output logic                    coefRdEn,
  output logic [ADDR_W-1:0]       coefAddr,
  input  logic [2*DATA_W-1:0]     coefData,
  output logic                    sampRdEn,
  output logic [ADDR_W-1:0]       sampAddr,
  input  logic [2*DATA_W-1:0]     sampData,
  output logic                    busy,
  output logic                    done,
  output logic [OUT_W-1:0]        result
);
  firStrobes_t strobes;

  fir_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pairCount(pairCount),
    .coefBase(coefBase), .coefMod(coefMod), .coefOfs(coefOfs),
    .sampBase(sampBase), .coefRdEn(coefRdEn), .coefAddr(coefAddr),
    .sampRdEn(sampRdEn), .sampAddr(sampAddr), .busy(busy), .done(done),
    .strobes(strobes)
  );

  fir_dp #(.DATA_W(DATA_W), .ACC_W(ACC_W), .OUT_W(OUT_W), .NACC(NACC)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .accSel(accSel),
    .shiftEn(shiftEn), .satEn(satEn), .coefData(coefData),
    .sampData(sampData), .result(result)
  );
endmodule

// File: tb/dual_mac_fir_tb.sv
module dual_mac_fir_tb;
  logic        clk = 0, rstN = 0, start = 0, shiftEn = 0, satEn = 0;
  logic [7:0]  pairCount = 0, coefBase = 0, coefMod = 1, coefOfs = 0, sampBase = 0;
  logic [2:0]  accSel = 0;
  logic        coefRdEn, sampRdEn, busy, done;
  logic [7:0]  coefAddr, sampAddr;
  logic [31:0] coefData = 0, sampData = 0, result;
  logic [31:0] cmem [256];
  logic [31:0] smem [256];
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  dual_mac_fir u_dut (.*);

  always @(posedge clk) begin
    if (coefRdEn) coefData <= cmem[coefAddr];
    if (sampRdEn) sampData <= smem[sampAddr];
  end

  initial begin
    #(200000 * 20);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic signed [31:0] scaleP(input logic signed [31:0] p, input bit sh);
    logic signed [32:0] t;
    t = p;
    if (!sh) return p;
    t = t <<< 1;
    if (t > 33'sd2147483647) return 32'h7fffffff;
    if (t < -33'sd2147483648) return 32'h80000000;
    return t[31:0];
  endfunction

  function automatic logic [31:0] model(input int n, cb, cm, co, sb, input bit sh, sat);
    logic signed [39:0] acc = 0;
    int ci = co;
    for (int k = 0; k < n; k++) begin
      logic [31:0] cw, sw;
      logic signed [31:0] ph, pl;
      cw = cmem[(cb + ci) % 256];
      sw = smem[(sb + k) % 256];
      ph = $signed(cw[31:16]) * $signed(sw[31:16]);
      pl = $signed(cw[15:0]) * $signed(sw[15:0]);
      acc = acc + 40'(scaleP(ph, sh)) + 40'(scaleP(pl, sh));
      ci = (ci + 1 == cm) ? 0 : ci + 1;
    end
    if (sat && acc > 40'sd2147483647) return 32'h7fffffff;
    if (sat && acc < -40'sd2147483648) return 32'h80000000;
    return acc[31:0];
  endfunction

  task automatic fillRand(input int seed);
    int s = seed;
    for (int i = 0; i < 256; i++) begin
      s = s * 1103515245 + 12345; cmem[i] = s;
      s = s * 1103515245 + 12345; smem[i] = s ^ (s >>> 7);
    end
  endtask

  task automatic fillConst(input logic [31:0] c, input logic [31:0] s);
    for (int i = 0; i < 256; i++) begin cmem[i] = c; smem[i] = s; end
  endtask

  task automatic resetCheck();
    @(negedge clk);
    chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
    chk(!coefRdEn && !sampRdEn, "R1 read enables after reset", {coefRdEn, sampRdEn}, 0);
    chk(result == 0, "R1 result after reset", result, 0);
  endtask

  task automatic runFir(input string tag, input int n, cb, cm, co, sb, sel,
                        input bit sh, sat, inject, input logic [31:0] hand, input bit useHand);
    logic [31:0] exp;
    int doneAt = 0, reads = 0, addrBad = 0, ci = co, k = 0, expAt;
    exp = useHand ? hand : model(n, cb, cm, co, sb, sh, sat);
    expAt = (n == 0) ? 1 : n + 4;
    @(negedge clk);
    start = 1; pairCount = 8'(n); coefBase = 8'(cb); coefMod = 8'(cm);
    coefOfs = 8'(co); sampBase = 8'(sb); accSel = 3'(sel); shiftEn = sh; satEn = sat;
    @(negedge clk);
    start = 0;
    for (int cyc = 1; cyc <= n + 12 && doneAt == 0; cyc++) begin
      if (coefRdEn) begin
        reads++;
        if (coefAddr != 8'(cb + ci) || sampAddr != 8'(sb + k) || !sampRdEn) addrBad++;
        ci = (ci + 1 == cm) ? 0 : ci + 1;
        k++;
      end
      if (done) doneAt = cyc;
      if (inject && cyc == 2) begin
        start = 1; pairCount = 1; accSel = 3'(sel ^ 1); shiftEn = !sh;
        satEn = !sat; coefBase = 8'(cb + 40); sampBase = 8'(sb + 40);
      end
      if (inject && cyc == 3) start = 0;
      @(negedge clk);
    end
    chk(doneAt == expAt, {tag, " R8 done cycle"}, doneAt, expAt);
    chk(reads == n, {tag, " R2 read count"}, reads, n);
    chk(addrBad == 0, {tag, " R3/R4 address sequence"}, addrBad, 0);
    chk(result == exp, {tag, " result"}, result, exp);
    chk(!done, {tag, " R8 done one cycle"}, done, 0);
  endtask

  initial begin
    fillConst(0, 0);
    repeat (3) @(negedge clk);
    rstN = 1;
    resetCheck();
    fillRand(11);
    runFir("R5 32 taps", 16, 0, 16, 0, 0, 0, 0, 0, 0, 0, 0);
    runFir("R2 rerun same job", 16, 0, 16, 0, 0, 0, 0, 0, 0, 0, 0);
    runFir("R5 other entry sat on", 16, 32, 16, 0, 64, 5, 0, 1, 0, 0, 0);
    fillRand(23);
    runFir("R3 R4 wrap", 10, 250, 3, 2, 250, 3, 0, 1, 0, 0, 0);
    fillConst(32'h80008000, 32'h80008000);
    runFir("R6 doubled product clamp", 2, 0, 4, 0, 0, 1, 1, 0, 0, 32'hFFFFFFFC, 1);
    runFir("R5 unshifted extremes", 2, 0, 4, 0, 0, 1, 0, 0, 0, 32'h00000000, 1);
    runFir("R7 positive clamp", 2, 0, 4, 0, 0, 1, 1, 1, 0, 32'h7FFFFFFF, 1);
    fillConst(32'h7fff7fff, 32'h80008000);
    runFir("R7 negative clamp", 4, 0, 4, 0, 0, 2, 0, 1, 0, 32'h80000000, 1);
    runFir("R7 no clamp low bits", 4, 0, 4, 0, 0, 2, 0, 0, 0, 32'h00040000, 1);
    runFir("R9 zero length", 0, 0, 4, 0, 0, 4, 0, 0, 0, 0, 1);
    fillRand(37);
    runFir("R10 start while busy", 8, 8, 5, 1, 16, 6, 0, 0, 1, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule